// File: doc/BRIEF.md
# Dual-Map Bus Slave Decoder

This block sits between a parallel bus slave port and the capture logic of an eight-channel sampling front end. It claims one 64 KB page of the bus address space. The same offsets in that page reach one of two things, depending on a mode bit. In register mode, a few low offsets carry commands and status words. In memory mode, the whole page reads as packed sample memory. Writes to two fixed offsets flip the mode. Those writes, like every other command write, work in either mode.

A matched access needs two things. The first is a recognised address modifier: the two standard codes select 24-bit addressing, and the two extended codes select 32-bit addressing. The second is a match between the upper page bits and the base-select pins. Each accepted access is acknowledged once, one cycle later. Command writes leave the block as single-cycle strobes to the capture controller; a DAC write loads a 12-bit setting.

A memory read issues a fetch with bank and sample index, and the sample store returns all eight channel samples on the next cycle. The block then packs the addressed four-channel group into a 32-bit word. The request side has no back-pressure. A request is taken in any cycle, back-to-back, and the response cannot be stalled, so a requester must take the data in the acknowledge cycle.

Top module: `dualmap_slave`

## Requirements
- R1: An access is accepted only when `bus_am` is 0x3D or 0x39 and `bus_addr[23:16]` equals `base_sel[7:0]`, or when `bus_am` is 0x0D or 0x09 and `bus_addr[31:16]` equals `base_sel`. Any other request gets no acknowledge, no strobe and no fetch.
- R2: Every accepted request, including back-to-back ones, gets exactly one `bus_ack` pulse, in the cycle after acceptance. `bus_rdata` is zero whenever `bus_ack` is low.
- R3: Reset leaves register mode (`mode_is_mem`=0). A write to offset 0x06 selects memory mode and a write to offset 0x04 selects register mode, from either mode. The new mode applies from the next access.
- R4: Writes in either mode to offset 0x00, 0x0C, 0x08 and 0x0A pulse `cmd_reset`, `cmd_stop`, `cmd_release_a` and `cmd_release_b` respectively. Each pulse lasts one cycle and coincides with the acknowledge.
- R5: A write to offset 0x02 loads `bus_wdata[11:0]` into `dac_value`, in either mode. `dac_value` resets to 0.
- R6: In register mode a read of offset 0x08 returns `latch_a` in bits 11:0, and a read of 0x0A returns `latch_b` there. Both words carry `a_idle` in bit 12, `a_full` in bit 13, `b_idle` in bit 14 and `b_full` in bit 15. Bits 31:16 are zero.
- R7: In register mode a read of offset 0x0C returns `event_count` in bits 15:0.
- R8: In memory mode a read pulses `mem_rd` in the acceptance cycle. `mem_bank` is offset bit 15 (0 is bank A), and `mem_index` is offset bits 13:2.
- R9: The memory-mode read word holds, in byte k, the sample of channel 4·g+k, where g is offset bit 14. Channel c sits at `mem_samples[8c+7:8c]`, captured the cycle after `mem_rd`.
- R10: A register-mode read of any offset other than 0x08, 0x0A and 0x0C returns zero and issues no fetch. A write to any offset other than 0x00–0x0C (even) is acknowledged but changes no mode, no DAC value and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 16 | Page base select; low 8 bits used in 24-bit addressing |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 write, 0 read |
| bus_am | input | 6 | Address modifier |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Acknowledge, one cycle after acceptance |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| latch_a | input | 12 | Bank A latch address |
| latch_b | input | 12 | Bank B latch address |
| a_idle | input | 1 | Bank A idle flag |
| a_full | input | 1 | Bank A full flag |
| b_idle | input | 1 | Bank B idle flag |
| b_full | input | 1 | Bank B full flag |
| event_count | input | 16 | Stop event count |
| mode_is_mem | output | 1 | 1 in memory mode |
| dac_value | output | 12 | DAC setting |
| cmd_reset | output | 1 | Reset strobe |
| cmd_stop | output | 1 | Software stop strobe |
| cmd_release_a | output | 1 | Release bank A strobe |
| cmd_release_b | output | 1 | Release bank B strobe |
| mem_rd | output | 1 | Sample fetch |
| mem_bank | output | 1 | Fetch bank, 0 A, 1 B |
| mem_index | output | 12 | Fetch sample index |
| mem_samples | input | 64 | All channel samples of the fetched index |

## Verification
The bench builds the block with its default parameters: eight channels of 8-bit samples and a 12-bit index, which gives a 16-bit page. With these values both quadrant bits are reachable, as are the two ends of the index (offsets 0x0000 and 0xBFFC) and both four-channel groups. Both addressing widths can be exercised against the same base-select value. A model of the sample store, driven from the fetch outputs, computes the expected packed word from the address alone.

// File: rtl/dualmap_pkg.sv
package dualmap_pkg;
  localparam int unsigned OFS_RESET   = 'h0000;
  localparam int unsigned OFS_DAC     = 'h0002;
  localparam int unsigned OFS_REGMODE = 'h0004;
  localparam int unsigned OFS_MEMMODE = 'h0006;
  localparam int unsigned OFS_BANK_A  = 'h0008;
  localparam int unsigned OFS_BANK_B  = 'h000A;
  localparam int unsigned OFS_EVENT   = 'h000C;

  localparam logic [5:0] AM_SHORT_SUP = 6'h3D;
  localparam logic [5:0] AM_SHORT_USR = 6'h39;
  localparam logic [5:0] AM_LONG_SUP  = 6'h0D;
  localparam logic [5:0] AM_LONG_USR  = 6'h09;

  typedef enum logic {MODE_REG = 1'b0, MODE_MEM = 1'b1} mode_e;

  typedef struct packed {
    logic reset;
    logic stop;
    logic rel_a;
    logic rel_b;
  } cmd_t;
endpackage

// File: rtl/dualmap_match.sv
module dualmap_match
  import dualmap_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 16,
  parameter int SHORT_W = 24
) (
  input  logic [5:0]               am,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-PAGE_W-1:0] base_sel,
  output logic                     hit
);
  localparam int SHORT_BITS = SHORT_W - PAGE_W;

  logic short_am, long_am, short_eq, long_eq;

  always_comb begin
    short_am = (am == AM_SHORT_SUP) || (am == AM_SHORT_USR);
    long_am  = (am == AM_LONG_SUP)  || (am == AM_LONG_USR);
    short_eq = addr[SHORT_W-1:PAGE_W] == base_sel[SHORT_BITS-1:0];
    long_eq  = addr[ADDR_W-1:PAGE_W] == base_sel;
    hit      = (short_am && short_eq) || (long_am && long_eq);
  end
endmodule

// File: rtl/dualmap_regs.sv
module dualmap_regs
  import dualmap_pkg::*;
#(
  parameter int PAGE_W  = 16,
  parameter int INDEX_W = 12,
  parameter int DAC_W   = 12,
  parameter int CNT_W   = 16,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [PAGE_W-1:0]  ofs,
  input  logic [DAC_W-1:0]   wdata,
  input  logic [INDEX_W-1:0] latch_a,
  input  logic [INDEX_W-1:0] latch_b,
  input  logic [3:0]         status,
  input  logic [CNT_W-1:0]   event_count,
  output logic               mode_mem,
  output logic [DAC_W-1:0]   dac_value,
  output cmd_t               cmd,
  output logic [REG_W-1:0]   rd_word
);
  mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_REG;
      dac_value <= '0;
      cmd       <= '0;
      rd_word   <= '0;
    end else begin
      cmd     <= '0;
      rd_word <= '0;
      if (wr_en) begin
        case (ofs)
          PAGE_W'(OFS_RESET):   cmd.reset <= 1'b1;
          PAGE_W'(OFS_DAC):     dac_value <= wdata;
          PAGE_W'(OFS_REGMODE): mode_q    <= MODE_REG;
          PAGE_W'(OFS_MEMMODE): mode_q    <= MODE_MEM;
          PAGE_W'(OFS_BANK_A):  cmd.rel_a <= 1'b1;
          PAGE_W'(OFS_BANK_B):  cmd.rel_b <= 1'b1;
          PAGE_W'(OFS_EVENT):   cmd.stop  <= 1'b1;
          default: ;
        endcase
      end
      if (rd_en) begin
        case (ofs)
          PAGE_W'(OFS_BANK_A): rd_word <= REG_W'({status, latch_a});
          PAGE_W'(OFS_BANK_B): rd_word <= REG_W'({status, latch_b});
          PAGE_W'(OFS_EVENT):  rd_word <= REG_W'(event_count);
          default: ;
        endcase
      end
    end
  end

  assign mode_mem = (mode_q == MODE_MEM);
endmodule

// File: rtl/dualmap_pack.sv
module dualmap_pack #(
  parameter int CHANNELS = 8,
  parameter int SAMPLE_W = 8,
  parameter int WORD_W   = 32,
  parameter int GRP_W    = 1
) (
  input  logic [CHANNELS*SAMPLE_W-1:0] samples,
  input  logic [GRP_W-1:0]             group,
  output logic [WORD_W-1:0]            word
);
  localparam int LANES = WORD_W / SAMPLE_W;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_comb
      word[lane*SAMPLE_W +: SAMPLE_W] =
        samples[(int'(group) * LANES + lane) * SAMPLE_W +: SAMPLE_W];
  end
endmodule

// File: rtl/dualmap_slave.sv
module dualmap_slave
  import dualmap_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int SAMPLE_W = 8,
  parameter int INDEX_W  = 12,
  parameter int DAC_W    = 12,
  parameter int CNT_W    = 16,
  localparam int ADDR_W  = 32,
  localparam int WORD_W  = 32,
  localparam int WDATA_W = 16,
  localparam int LANES   = WORD_W / SAMPLE_W,
  localparam int GROUPS  = CHANNELS / LANES,
  localparam int GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int PAGE_W  = INDEX_W + 2 + GRP_W + 1,
  localparam int BASE_W  = ADDR_W - PAGE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [BASE_W-1:0]            base_sel,
  input  logic                         bus_req,
  input  logic                         bus_write,
  input  logic [5:0]                   bus_am,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [WDATA_W-1:0]           bus_wdata,
  output logic                         bus_ack,
  output logic [WORD_W-1:0]            bus_rdata,
  input  logic [INDEX_W-1:0]           latch_a,
  input  logic [INDEX_W-1:0]           latch_b,
  input  logic                         a_idle,
  input  logic                         a_full,
  input  logic                         b_idle,
  input  logic                         b_full,
  input  logic [CNT_W-1:0]             event_count,
  output logic                         mode_is_mem,
  output logic [DAC_W-1:0]             dac_value,
  output logic                         cmd_reset,
  output logic                         cmd_stop,
  output logic                         cmd_release_a,
  output logic                         cmd_release_b,
  output logic                         mem_rd,
  output logic                         mem_bank,
  output logic [INDEX_W-1:0]           mem_index,
  input  logic [CHANNELS*SAMPLE_W-1:0] mem_samples
);
  localparam int REG_W = INDEX_W + 4;

  logic              hit, accept, wr_acc, rd_acc, reg_rd;
  logic [PAGE_W-1:0] ofs;
  logic [GRP_W-1:0]  group, group_q;
  logic              mem_q;
  logic [REG_W-1:0]  rd_word;
  logic [WORD_W-1:0] packed_word;
  cmd_t              cmd;
  logic              unused_wdata;

  dualmap_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_match (
    .am(bus_am), .addr(bus_addr), .base_sel(base_sel), .hit(hit)
  );

  assign ofs    = bus_addr[PAGE_W-1:0];
  assign accept = bus_req && hit;
  assign wr_acc = accept && bus_write;
  assign rd_acc = accept && !bus_write;
  assign reg_rd = rd_acc && !mode_is_mem;

  assign mem_rd    = rd_acc && mode_is_mem;
  assign mem_bank  = ofs[PAGE_W-1];
  assign group     = ofs[PAGE_W-2 -: GRP_W];
  assign mem_index = ofs[INDEX_W+1:2];

  assign unused_wdata = ^bus_wdata[WDATA_W-1:DAC_W];

  dualmap_regs #(
    .PAGE_W(PAGE_W), .INDEX_W(INDEX_W), .DAC_W(DAC_W), .CNT_W(CNT_W), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .rd_en(reg_rd), .ofs(ofs),
    .wdata(bus_wdata[DAC_W-1:0]), .latch_a(latch_a), .latch_b(latch_b),
    .status({b_full, b_idle, a_full, a_idle}), .event_count(event_count),
    .mode_mem(mode_is_mem), .dac_value(dac_value), .cmd(cmd), .rd_word(rd_word)
  );

  dualmap_pack #(
    .CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .GRP_W(GRP_W)
  ) u_pack (
    .samples(mem_samples), .group(group_q), .word(packed_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      mem_q   <= 1'b0;
      group_q <= '0;
    end else begin
      bus_ack <= accept;
      mem_q   <= mem_rd;
      group_q <= group;
    end
  end

  always_comb begin
    if (!bus_ack)   bus_rdata = '0;
    else if (mem_q) bus_rdata = packed_word;
    else            bus_rdata = WORD_W'(rd_word);
  end

  assign cmd_reset     = cmd.reset;
  assign cmd_stop      = cmd.stop;
  assign cmd_release_a = cmd.rel_a;
  assign cmd_release_b = cmd.rel_b;
endmodule

// File: rtl/dualmap_slave_chk.sv
module dualmap_slave_chk #(
  parameter int DAC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_write,
  input logic             bus_ack,
  input logic [31:0]      bus_rdata,
  input logic             mem_rd,
  input logic             mode_is_mem,
  input logic [DAC_W-1:0] dac_value,
  input logic             cmd_reset,
  input logic             cmd_stop,
  input logic             cmd_release_a,
  input logic             cmd_release_b
);
  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_req));

  assert_quiet_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdata == '0));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_reset, cmd_stop, cmd_release_a, cmd_release_b}));

  assert_strobe_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reset || cmd_stop || cmd_release_a || cmd_release_b) |-> bus_ack);

  assert_dac_by_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_value) |-> bus_ack);

  assert_mode_by_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_is_mem) |-> bus_ack);

  assert_fetch_mem_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mode_is_mem && !bus_write && bus_req));

  assert_fetch_acked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> bus_ack);
endmodule

bind dualmap_slave dualmap_slave_chk #(.DAC_W(DAC_W)) u_chk (.*);

// File: tb/test_dualmap_slave.sv
module test_dualmap_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] base_sel = 16'h12AB;
  logic        bus_req = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_am = '0;
  logic [31:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [11:0] latch_a = 12'hA5C, latch_b = 12'h3F1;
  logic        a_idle = 1'b1, a_full = 1'b0, b_idle = 1'b0, b_full = 1'b1;
  logic [15:0] event_count = 16'hBEEF;
  logic        mode_is_mem;
  logic [11:0] dac_value;
  logic        cmd_reset, cmd_stop, cmd_release_a, cmd_release_b;
  logic        mem_rd, mem_bank;
  logic [11:0] mem_index;
  logic [63:0] mem_samples = '0;

  always #10 clk = ~clk;

  dualmap_slave i_dualmap_slave (.*);

  typedef struct {
    logic [31:0] rd;
    logic [3:0]  cmd;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model_mem = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] samp(input logic bank, input logic [11:0] idx, input int ch);
    return 8'(int'(idx) * 7 + ch * 37 + int'(bank) * 91 + 5);
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++)
      w[k*8 +: 8] = samp(a[15], a[13:2], int'(a[14]) * 4 + k);
    return w;
  endfunction

  // Sample store model: answers a fetch on the next cycle.
  always @(posedge clk)
    if (mem_rd)
      for (int ch = 0; ch < 8; ch++)
        mem_samples[ch*8 +: 8] <= samp(mem_bank, mem_index, ch);

  // Monitor: pops expected responses as acknowledges appear.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] cmdv;
      cmdv = {cmd_reset, cmd_stop, cmd_release_a, cmd_release_b};
      if (bus_ack) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected ack", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(bus_rdata == e.rd, e.req, "read data", bus_rdata, e.rd);
          chk(cmdv == e.cmd, e.req, "strobes", 32'(cmdv), 32'(e.cmd));
        end
      end else if (cmdv != 4'b0) begin
        chk(1'b0, "R4", "strobe without ack", 32'(cmdv), 32'd0);
      end
    end
  end

  task automatic issue(input bit wr, input logic [5:0] am, input logic [31:0] addr,
                       input logic [15:0] wd, input bit expect_ack,
                       input logic [31:0] exp_rd, input logic [3:0] exp_cmd,
                       input string req);
    bit exp_fetch;
    exp_fetch = expect_ack && !wr && model_mem;
    bus_req   = 1'b1;
    bus_write = wr;
    bus_am    = am;
    bus_addr  = addr;
    bus_wdata = wd;
    if (expect_ack) begin
      exp_t e;
      e.rd = exp_rd; e.cmd = exp_cmd; e.req = req;
      exp_q.push_back(e);
    end
    #1;
    chk(mem_rd == exp_fetch, exp_fetch ? "R8" : "R10", "mem_rd", 32'(mem_rd), 32'(exp_fetch));
    if (exp_fetch) begin
      chk(mem_bank == addr[15], "R8", "mem_bank", 32'(mem_bank), 32'(addr[15]));
      chk(mem_index == addr[13:2], "R8", "mem_index", 32'(mem_index), 32'(addr[13:2]));
    end
    @(negedge clk);
    if (!expect_ack) chk(bus_ack == 1'b0, "R1", "rejected access acked", 32'(bus_ack), 32'd0);
    if (expect_ack && wr && addr[15:0] == 16'h0006) model_mem = 1'b1;
    if (expect_ack && wr && addr[15:0] == 16'h0004) model_mem = 1'b0;
  endtask

  task automatic quiet(input int n);
    bus_req = 1'b0;
    bus_write = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(bus_ack == 1'b0, "R2", "ack after reset", 32'(bus_ack), 0);
    chk(bus_rdata == 32'd0, "R2", "rdata after reset", bus_rdata, 0);
    chk(mode_is_mem == 1'b0, "R3", "mode after reset", 32'(mode_is_mem), 0);
    chk(dac_value == 12'd0, "R5", "dac after reset", 32'(dac_value), 0);

    // R6 status words, both addressing widths (R1)
    issue(0, 6'h3D, 32'h00AB_0008, 0, 1, 32'h0000_9A5C, 4'b0, "R6");
    issue(0, 6'h0D, 32'h12AB_000A, 0, 1, 32'h0000_93F1, 4'b0, "R6");
    // R7 event counter, extended user code
    issue(0, 6'h09, 32'h12AB_000C, 0, 1, 32'h0000_BEEF, 4'b0, "R7");
    // R1 short addressing ignores bits 31:24
    issue(0, 6'h39, 32'hFFAB_000C, 0, 1, 32'h0000_BEEF, 4'b0, "R1");
    quiet(1);
    // R1 rejects
    issue(0, 6'h3D, 32'h00AC_0008, 0, 0, 0, 4'b0, "R1");
    issue(1, 6'h3E, 32'h00AB_0000, 0, 0, 0, 4'b0, "R1");
    issue(1, 6'h0D, 32'h13AB_000C, 0, 0, 0, 4'b0, "R1");
    issue(0, 6'h0D, 32'h00AB_0008, 0, 0, 0, 4'b0, "R1");
    quiet(2);

    // R5 DAC
    issue(1, 6'h3D, 32'h00AB_0002, 16'hF123, 1, 0, 4'b0, "R5");
    quiet(1);
    chk(dac_value == 12'h123, "R5", "dac load", 32'(dac_value), 32'h123);

    // R4 strobes, back-to-back
    issue(1, 6'h3D, 32'h00AB_0000, 0, 1, 0, 4'b1000, "R4");
    issue(1, 6'h3D, 32'h00AB_000C, 0, 1, 0, 4'b0100, "R4");
    issue(1, 6'h0D, 32'h12AB_0008, 0, 1, 0, 4'b0010, "R4");
    issue(1, 6'h0D, 32'h12AB_000A, 0, 1, 0, 4'b0001, "R4");
    quiet(2);

    // R10 unmapped offsets
    issue(0, 6'h3D, 32'h00AB_000E, 0, 1, 0, 4'b0, "R10");
    issue(0, 6'h3D, 32'h00AB_0000, 0, 1, 0, 4'b0, "R10");
    issue(0, 6'h3D, 32'h00AB_4008, 0, 1, 0, 4'b0, "R10");
    issue(1, 6'h3D, 32'h00AB_0010, 16'h0FFF, 1, 0, 4'b0, "R10");
    issue(1, 6'h3D, 32'h00AB_8002, 16'h0FFF, 1, 0, 4'b0, "R10");
    quiet(2);
    chk(dac_value == 12'h123, "R10", "dac after ignored write", 32'(dac_value), 32'h123);
    chk(mode_is_mem == 1'b0, "R10", "mode after ignored write", 32'(mode_is_mem), 0);

    // R3 switch to memory mode
    issue(1, 6'h3D, 32'h00AB_0006, 0, 1, 0, 4'b0, "R3");
    quiet(1);
    chk(mode_is_mem == 1'b1, "R3", "memory mode", 32'(mode_is_mem), 1);

    // R8 / R9 memory reads, back-to-back, all quadrants and index ends
    issue(0, 6'h3D, 32'h00AB_0000, 0, 1, mem_word(32'h0000), 4'b0, "R9");
    issue(0, 6'h3D, 32'h00AB_4004, 0, 1, mem_word(32'h4004), 4'b0, "R9");
    issue(0, 6'h0D, 32'h12AB_BFFC, 0, 1, mem_word(32'hBFFC), 4'b0, "R9");
    issue(0, 6'h0D, 32'h12AB_C010, 0, 1, mem_word(32'hC010), 4'b0, "R9");
    issue(0, 6'h3D, 32'h00AB_7FFC, 0, 1, mem_word(32'h7FFC), 4'b0, "R9");
    // Offset that is a status word in register mode reads memory here
    issue(0, 6'h3D, 32'h00AB_0008, 0, 1, mem_word(32'h0008), 4'b0, "R8");
    quiet(1);
    // Commands and DAC still work in memory mode
    issue(1, 6'h3D, 32'h00AB_000C, 0, 1, 0, 4'b0100, "R4");
    issue(1, 6'h3D, 32'h00AB_0002, 16'h0ABC, 1, 0, 4'b0, "R5");
    issue(1, 6'h3D, 32'h00AB_0006, 0, 1, 0, 4'b0, "R3");
    quiet(1);
    chk(dac_value == 12'hABC, "R5", "dac in memory mode", 32'(dac_value), 32'hABC);
    chk(mode_is_mem == 1'b1, "R3", "memory mode held", 32'(mode_is_mem), 1);

    // R3 back to register mode, applies to the very next access
    issue(1, 6'h3D, 32'h00AB_0004, 0, 1, 0, 4'b0, "R3");
    issue(0, 6'h3D, 32'h00AB_0008, 0, 1, 32'h0000_9A5C, 4'b0, "R3");
    quiet(1);
    chk(mode_is_mem == 1'b0, "R3", "register mode", 32'(mode_is_mem), 0);

    // R6 status bits follow inputs
    a_idle = 1'b0; a_full = 1'b1; b_idle = 1'b1; b_full = 1'b0;
    issue(0, 6'h39, 32'h00AB_000A, 0, 1, 32'h0000_63F1, 4'b0, "R6");
    quiet(3);

    chk(exp_q.size() == 0, "R2", "missing acks", 32'(exp_q.size()), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule